// File: doc/BRIEF.md
# Card host status and interrupt unit

This unit gathers the 24 condition flags of a storage-card host controller into one status word, masks that word with a per-bit interrupt enable, and drives one interrupt line. Most of the flags are events. The event logic delivers each one as a single-cycle pulse, and the flag stays set until software clears it by writing a one to the clear register. The remaining flags are live levels, such as busy indications and FIFO fill states, and the status word shows them as they are at that moment.

Software uses a plain register port with a 2-bit register select and single-cycle read and write strobes. Select 0 reads the status word. Select 1 is the write-one-to-clear register, and select 2 is the enable mask, which can be read and written. Read data is registered and appears on the cycle after the read strobe. The set of flags that can be cleared is a parameter, and its default is the 13 event positions.

Top module: `card_irq_status`

## Requirements
- R1: After reset the status word reads 0 while all live inputs are low, the enable mask reads 0, and the interrupt line is low.
- R2: A one-cycle pulse on the event input of a sticky position (bits 0 to 10, 22, 23) sets that status bit on the next clock edge. The bit stays set after the pulse ends.
- R3: A write to select 1 clears each sticky status bit whose write-data bit is 1. The clear takes effect on the edge that samples the write strobe, so the cleared value is visible from the next cycle. Sticky bits written with 0 keep their value.
- R4: If an event pulse and a clear for the same sticky bit arrive in the same cycle, the bit ends up set.
- R5: Status bits 11 to 21 show the live-level inputs at the same positions, and a clear write does not change them.
- R6: The live-level inputs at sticky positions are ignored, and so are the event inputs at live positions (bits 11 to 21).
- R7: A write to select 2 loads write-data bits 23:0 into the enable mask. Reading select 2 returns the mask, with bits 31:24 read as 0.
- R8: The interrupt output is a register that holds the OR over all 24 positions of (status AND enable). It follows a change in status or enable one clock edge later.
- R9: Read data for a strobe appears on the cycle after it. Selects 1 and 3 read as 0, status bits 31:24 read as 0, and writes to select 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | 24 | Event pulses, used at sticky positions only |
| lvl_i | input | 24 | Live-level conditions, used at live positions only |
| sel_i | input | 2 | Register select: 0 status, 1 clear, 2 enable |
| wr_en_i | input | 1 | Single-cycle write strobe |
| wdata_i | input | 32 | Write data |
| rd_en_i | input | 1 | Single-cycle read strobe |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Registered interrupt line |

## Verification
Each result arrives a fixed number of edges after its stimulus, and the bench checks it at that point. A sticky flag or a clear is in place one edge after its pulse or write. Read data for a strobe is ready one edge after that strobe. The interrupt line trails the status and enable state that produce it by one more edge. The bench drives inputs on falling edges. Each read strobe pushes an expected word into a queue, and a monitor pops that word on the falling edge after the capturing edge. Interrupt checks are taken one full cycle after the state they depend on has settled.

// File: rtl/card_stat_pkg.sv
package card_stat_pkg;

   localparam int unsigned STAT_BITS = 24;
   localparam int unsigned SEL_W     = 2;

   // Positions that latch events; the rest follow live levels.
   localparam logic [STAT_BITS-1:0] STICKY_DEFAULT = 24'hC0_07FF;

   typedef enum logic [SEL_W-1:0] {
      SEL_STATUS = 2'd0,
      SEL_CLEAR  = 2'd1,
      SEL_ENABLE = 2'd2,
      SEL_SPARE  = 2'd3
   } reg_sel_e;

endpackage

// File: rtl/card_stat_flags.sv
module card_stat_flags #(
   parameter int unsigned              NUM_BITS    = 24,
   parameter logic [NUM_BITS-1:0]      STICKY_MASK = '1
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [NUM_BITS-1:0] evt_i,
   input  logic [NUM_BITS-1:0] lvl_i,
   input  logic [NUM_BITS-1:0] clr_i,
   output logic [NUM_BITS-1:0] status_o
);

   for (genvar b = 0; b < NUM_BITS; b++) begin : g_bit
      if (STICKY_MASK[b]) begin : g_sticky
         logic flag_q;
         logic lvl_unused;
         assign lvl_unused = lvl_i[b];

         // Set has priority over clear on a shared cycle.
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)          flag_q <= 1'b0;
            else if (evt_i[b])    flag_q <= 1'b1;
            else if (clr_i[b])    flag_q <= 1'b0;
         end
         assign status_o[b] = flag_q;

         // R2 and R4
         evt_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            evt_i[b] |=> status_o[b]);
         // R3
         clr_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (clr_i[b] && !evt_i[b]) |=> !status_o[b]);
         // R2
         hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (status_o[b] && !clr_i[b]) |=> status_o[b]);
      end else begin : g_level
         logic evt_unused;
         logic clr_unused;
         assign evt_unused  = evt_i[b];
         assign clr_unused  = clr_i[b];
         assign status_o[b] = lvl_i[b];
      end
   end

endmodule

// File: rtl/card_stat_enable.sv
module card_stat_enable #(
   parameter int unsigned NUM_BITS = 24
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                we_i,
   input  logic [NUM_BITS-1:0] wdata_i,
   output logic [NUM_BITS-1:0] en_o
);

   logic [NUM_BITS-1:0] en_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   en_q <= '0;
      else if (we_i) en_q <= wdata_i;
   end
   assign en_o = en_q;

   // R7
   en_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_i |=> (en_o == $past(wdata_i)));
   // R7
   en_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !we_i |=> $stable(en_o));

endmodule

// File: rtl/card_stat_irq.sv
module card_stat_irq #(
   parameter int unsigned NUM_BITS = 24
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [NUM_BITS-1:0] status_i,
   input  logic [NUM_BITS-1:0] en_i,
   output logic                irq_o
);

   logic pend_w;
   logic irq_q;

   assign pend_w = |(status_i & en_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_q <= 1'b0;
      else         irq_q <= pend_w;
   end
   assign irq_o = irq_q;

   // R8
   irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(status_i & en_i)) |=> irq_o);
   // R8
   irq_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!(|(status_i & en_i))) |=> !irq_o);

endmodule

// File: rtl/card_irq_status.sv
module card_irq_status
   import card_stat_pkg::*;
#(
   parameter int unsigned             NUM_BITS    = STAT_BITS,
   parameter int unsigned             BUS_W       = 32,
   parameter logic [NUM_BITS-1:0]     STICKY_MASK = STICKY_DEFAULT
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [NUM_BITS-1:0] evt_i,
   input  logic [NUM_BITS-1:0] lvl_i,
   input  logic [SEL_W-1:0]    sel_i,
   input  logic                wr_en_i,
   input  logic [BUS_W-1:0]    wdata_i,
   input  logic                rd_en_i,
   output logic [BUS_W-1:0]    rdata_o,
   output logic                irq_o
);

   localparam int unsigned PAD_W = BUS_W - NUM_BITS;

   if (BUS_W < NUM_BITS) begin : g_bad_width
      $error("card_irq_status: BUS_W must cover NUM_BITS");
   end
   if (NUM_BITS == 0) begin : g_bad_count
      $error("card_irq_status: NUM_BITS must be nonzero");
   end

   reg_sel_e            sel_w;
   logic [NUM_BITS-1:0] wlow_w;
   logic [NUM_BITS-1:0] clr_w;
   logic                en_we_w;
   logic [NUM_BITS-1:0] status_w;
   logic [NUM_BITS-1:0] en_w;
   logic [BUS_W-1:0]    rdata_q;

   assign sel_w   = reg_sel_e'(sel_i);
   assign wlow_w  = wdata_i[NUM_BITS-1:0];
   assign clr_w   = (wr_en_i && sel_w == SEL_CLEAR) ? (wlow_w & STICKY_MASK) : '0;
   assign en_we_w = wr_en_i && (sel_w == SEL_ENABLE);

   if (PAD_W > 0) begin : g_pad
      logic wtop_unused;
      assign wtop_unused = ^wdata_i[BUS_W-1:NUM_BITS];
   end

   card_stat_flags #(
      .NUM_BITS    (NUM_BITS),
      .STICKY_MASK (STICKY_MASK)
   ) u_flags (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .evt_i    (evt_i),
      .lvl_i    (lvl_i),
      .clr_i    (clr_w),
      .status_o (status_w)
   );

   card_stat_enable #(
      .NUM_BITS (NUM_BITS)
   ) u_enable (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (en_we_w),
      .wdata_i (wlow_w),
      .en_o    (en_w)
   );

   card_stat_irq #(
      .NUM_BITS (NUM_BITS)
   ) u_irq (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .status_i (status_w),
      .en_i     (en_w),
      .irq_o    (irq_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rdata_q <= '0;
      end else if (rd_en_i) begin
         case (sel_w)
            SEL_STATUS: rdata_q <= BUS_W'(status_w);
            SEL_ENABLE: rdata_q <= BUS_W'(en_w);
            default:    rdata_q <= '0;
         endcase
      end
   end
   assign rdata_o = rdata_q;

   // R9
   clr_reads_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en_i && sel_w == SEL_CLEAR) |=> (rdata_o == '0));
   // R9
   rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_en_i |=> $stable(rdata_o));
   // R7
   en_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en_i && sel_w == SEL_ENABLE) |=> (rdata_o == BUS_W'($past(en_w))));

endmodule

// File: tb/card_irq_status_tb.sv
`timescale 1ns/1ps
module card_irq_status_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] evt = '0;
   logic [23:0] lvl = '0;
   logic [1:0]  sel = '0;
   logic        wr_en = 1'b0;
   logic [31:0] wdata = '0;
   logic        rd_en = 1'b0;
   logic [31:0] rdata;
   logic        irq;

   int unsigned total = 0;
   int unsigned bad   = 0;
   bit          done  = 1'b0;
   logic        rd_pend = 1'b0;

   typedef struct {
      logic [31:0] exp;
      string       tag;
   } item_t;
   item_t sb_q[$];

   always #2.5 clk = ~clk;

   card_irq_status u_dut (
      .clk_i   (clk),
      .rst_ni  (rst_n),
      .evt_i   (evt),
      .lvl_i   (lvl),
      .sel_i   (sel),
      .wr_en_i (wr_en),
      .wdata_i (wdata),
      .rd_en_i (rd_en),
      .rdata_o (rdata),
      .irq_o   (irq)
   );

   always @(posedge clk) rd_pend <= rd_en;

   // Monitor: read data is stable between the capturing edge and the next.
   always @(negedge clk) begin : mon
      item_t it;
      if (rd_pend) begin
         if (sb_q.size() == 0) begin
            total++; bad++;
            $display("FAIL scoreboard: read data with no expected item, actual=%h expected=none", rdata);
         end else begin
            it = sb_q.pop_front();
            total++;
            if (rdata !== it.exp) begin
               bad++;
               $display("FAIL %s: actual=%h expected=%h", it.tag, rdata, it.exp);
            end
         end
      end
   end

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; sel = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; wdata = '0;
   endtask

   task automatic rd(input logic [1:0] a, input logic [31:0] e, input string tag);
      item_t it;
      @(negedge clk);
      it.exp = e; it.tag = tag;
      sb_q.push_back(it);
      rd_en = 1'b1; sel = a;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic pulse(input logic [23:0] bits);
      @(negedge clk);
      evt = bits;
      @(negedge clk);
      evt = '0;
   endtask

   task automatic chk_irq(input logic e, input string tag);
      total++;
      if (irq !== e) begin
         bad++;
         $display("FAIL %s: irq actual=%b expected=%b", tag, irq, e);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin : drive
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(2'd0, 32'h0, "R1 status after reset");
      rd(2'd2, 32'h0, "R1 enable after reset");
      chk_irq(1'b0, "R1 irq after reset");

      // R2 events latch and hold; R8 masked while enable is zero
      pulse(24'h80_0001);
      rd(2'd0, 32'h0080_0001, "R2 sticky bits 0 and 23");
      chk_irq(1'b0, "R8 masked event keeps irq low");

      // R7 enable write, R8 irq raise
      wr(2'd2, 32'h0000_0001);
      rd(2'd2, 32'h0000_0001, "R7 enable readback");
      chk_irq(1'b1, "R8 irq raised by enabled bit 0");

      // R3 clear bit 0 only
      wr(2'd1, 32'h0000_0001);
      @(negedge clk);
      chk_irq(1'b0, "R8 irq drops after clear");
      rd(2'd0, 32'h0080_0000, "R3 bit 0 cleared, bit 23 kept");

      // R4 set wins over same-cycle clear
      @(negedge clk);
      evt = 24'h00_0020; wr_en = 1'b1; sel = 2'd1; wdata = 32'h0000_0020;
      @(negedge clk);
      evt = '0; wr_en = 1'b0; wdata = '0;
      rd(2'd0, 32'h0080_0020, "R4 set wins over clear");

      // R9 writes to status select ignored
      wr(2'd0, 32'h0000_0000);
      rd(2'd0, 32'h0080_0020, "R9 status write ignored");

      // R5 and R6 live levels, sticky-position levels ignored
      @(negedge clk);
      lvl = 24'hFF_FFFF;
      rd(2'd0, 32'h00BF_F820, "R5 R6 live bits shown, sticky-position levels ignored");
      wr(2'd1, 32'hFFFF_FFFF);
      rd(2'd0, 32'h003F_F800, "R5 clear leaves live bits");

      // R6 events at live positions ignored
      @(negedge clk);
      lvl = '0;
      pulse(24'h3F_F800);
      rd(2'd0, 32'h0000_0000, "R6 events at live positions ignored");

      // R7 upper bits, R9 unused selects
      wr(2'd2, 32'hFFFF_FFFF);
      rd(2'd2, 32'h00FF_FFFF, "R7 enable upper bits read zero");
      rd(2'd1, 32'h0, "R9 clear select reads zero");
      rd(2'd3, 32'h0, "R9 spare select reads zero");
      chk_irq(1'b0, "R8 no status, no irq");

      // R8 irq from a live level
      @(negedge clk);
      lvl = 24'h00_4000;
      @(negedge clk);
      chk_irq(1'b1, "R8 irq follows live bit 14");
      lvl = '0;
      @(negedge clk);
      chk_irq(1'b0, "R8 irq falls with live bit 14");

      // R2 bit 22 event
      pulse(24'h40_0000);
      @(negedge clk);
      chk_irq(1'b1, "R2 R8 bit 22 event raises irq");
      rd(2'd0, 32'h0040_0000, "R2 bit 22 latched");

      repeat (3) @(negedge clk);
      total++;
      if (sb_q.size() != 0) begin
         bad++;
         $display("FAIL R9: pending reads actual=%0d expected=0", sb_q.size());
      end
      finish_run();
   end

endmodule